// File: doc/BRIEF.md
# Two-wire target with control register bank

This block sits on a two-wire serial bus (SCL clock, SDA data, both open-drain) as a target device. It gives a bus host read and write access to eleven 8-bit control registers at addresses 0x00 to 0x0A. Every register's contents also leave the block as parallel control bits for the rest of the chip. Both bus lines are brought into a faster system clock domain. Start and stop conditions are recognised there. A single state machine then receives and sends bytes bit by bit, answers with acknowledge bits, and keeps a register pointer.

A write transfer has four parts: a start, the 7-bit device address with R/W = 0, one pointer byte, and any number of data bytes. A read uses the same address with R/W = 1 and returns registers starting at the pointer. The pointer can be set by an earlier write, either across a repeated start or across a stop followed by a new start. The pointer stops advancing at the last register, so further reads keep returning that register.

The state machine has ten states.
- IDLE: waits for a start.
- ADDR: shifts in the address byte. A match goes to ADDR_ACK; a mismatch goes to SKIP.
- ADDR_ACK: after the acknowledge bit, goes to PTR when R/W = 0 or to RDATA when R/W = 1.
- PTR: takes the pointer byte and goes to PTR_ACK.
- PTR_ACK: goes to WDATA.
- WDATA: takes a data byte, writes the register, advances the pointer and goes to WDATA_ACK.
- WDATA_ACK: goes back to WDATA.
- RDATA: shifts a register out MSB first, advances the pointer and goes to RACK.
- RACK: samples the host's acknowledge. An ACK returns to RDATA with the next register; a NACK goes to SKIP.
- SKIP: ignores the bus until the next start.

A start seen in any state goes to ADDR. A stop seen in any state goes to IDLE.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all registers and the pointer to 0x00 and releases SDA (sda_oe = 0).
- R2: The 7-bit device address is binary 10110 followed by addr_sel[1:0] (addr_sel[1] is the higher bit). The address byte is sent MSB first with R/W in bit 0. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: A non-matching address is not acknowledged. Every following byte is ignored and left unacknowledged until the next start, and no register changes.
- R4: In a write, the pointer byte and every data byte are acknowledged. Each data byte is stored in the register the pointer selects. Register i appears on ctrl_bits[8*i+7 : 8*i].
- R5: The pointer advances by one after each data byte written or read. When it is already at 0x0A or above, it keeps its value.
- R6: In a read, bytes are sent MSB first, starting with the register at the pointer. Each later byte comes from the next register.
- R7: The pointer keeps its value across a stop followed by a new start, so a read after a stop continues from the pointer written before it.
- R8: Once the pointer reaches 0x0A, every further read byte returns register 0x0A.
- R9: When the host does not acknowledge a read byte (SDA high in the ninth clock), the target releases SDA and drives nothing more until the next start.
- R10: With the pointer above 0x0A, read bytes return 0x00. Written bytes are acknowledged but change no register.
- R11: A start or stop that arrives before the eighth bit of a byte ends the transfer and changes no register.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_bits | output | 88 | All registers, register i in bits 8*i+7 : 8*i |

## Verification
The bench writes past the top register and reads back across the 0x09-to-0x0A boundary. A design that wraps the pointer instead of saturating would overwrite register 0x00 on that write, and would return registers 0x00 and 0x01 on that read. It aims a stop and a start into the middle of a data byte. A design that commits partial bytes would corrupt registers 0x01 and 0x02 there. It also sends a foreign address followed by data, and points at an address above 0x0A. A design that decodes addresses loosely would acknowledge the foreign address or change a register, and would return data other than 0x00 from the out-of-range pointer. Finally, it follows a read that ends in a NACK with a fresh transfer. The pointer is also carried across a stop, and a design that resets the pointer at a stop would return the wrong first register there.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Both lines idle high on an open-drain bus, so reset to 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Start: SDA falls while SCL stays high. Stop: SDA rises while SCL stays high.
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int NREG = 11,
    parameter int DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [DW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [NREG*DW-1:0]   regs_flat
);
    logic [NREG-1:0][DW-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == DW'(i)) mem[i] <= wr_data;
            end
        end
    end

    // Out-of-range addresses read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == DW'(i)) rd_data = mem[i];
        end
    end

    assign regs_flat = mem;

    // R10
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= DW'(NREG)) |=> $stable(regs_flat));

    // R4
    inrange_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> (regs_flat[DW-1:0] == $past(wr_data)));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_rb_pkg::*;
#(
    parameter int         NREG       = 11,
    parameter int         DW         = 8,
    parameter logic [4:0] DEV_PREFIX = 5'b10110
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [1:0]    addr_sel,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [DW-1:0] LAST = DW'(NREG - 1);

    tgt_state_t    state;
    logic [DW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic [DW-1:0] ptr;
    logic          rw;
    logic          host_ack;

    logic          byte_full;
    logic          addr_hit;
    logic          receiving;
    logic [DW-1:0] ptr_adv;
    logic          ptr_load;

    assign byte_full = (cnt == CW'(DW));
    assign addr_hit  = (shreg[DW-1:1] == {DEV_PREFIX, addr_sel});
    assign receiving = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
    assign ptr_adv   = (ptr >= LAST) ? ptr : ptr + 1'b1;
    assign ptr_load  = (state == ST_PTR) && scl_fall && byte_full;

    // State register and data path
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
        end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else if (receiving) begin
            if (scl_rise && !byte_full) begin
                shreg <= {shreg[DW-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
                cnt <= '0;
                if (state == ST_ADDR) begin
                    if (addr_hit) begin
                        state <= ST_ADDR_ACK;
                        rw    <= shreg[0];
                    end else begin
                        state <= ST_SKIP;
                    end
                end else if (state == ST_PTR) begin
                    state <= ST_PTR_ACK;
                    ptr   <= shreg;
                end else begin
                    state <= ST_WDATA_ACK;
                    ptr   <= ptr_adv;
                end
            end
        end else begin
            unique case (state)
                ST_ADDR_ACK: if (scl_fall) begin
                    cnt <= '0;
                    if (rw) begin
                        state <= ST_RDATA;
                        shreg <= rd_data;
                    end else begin
                        state <= ST_PTR;
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) begin
                    state <= ST_WDATA;
                    cnt   <= '0;
                end
                ST_RDATA: if (scl_fall) begin
                    if (cnt == CW'(DW - 1)) begin
                        state <= ST_RACK;
                        ptr   <= ptr_adv;
                        cnt   <= '0;
                    end else begin
                        shreg <= {shreg[DW-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            state <= ST_RDATA;
                            shreg <= rd_data;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[DW-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = (state == ST_WDATA) && scl_fall && byte_full && !start_det && !stop_det;
    assign wr_addr = ptr;
    assign wr_data = shreg;
    assign rd_addr = ptr;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ptr == '0 && !sda_oe));

    // R12
    oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr >= LAST && !ptr_load) |=> (ptr == $past(ptr)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr < LAST) |=> (ptr == $past(wr_addr) + 1'b1));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && scl_fall && !host_ack && !start_det && !stop_det) |=> !sda_oe);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter int         NREG        = 11,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_PREFIX  = 5'b10110
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [1:0]         addr_sel,
    output logic               sda_oe,
    output logic [NREG*DW-1:0] ctrl_bits
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [DW-1:0] wr_addr, wr_data, rd_addr, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.NREG(NREG), .DW(DW), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_reg_store #(.NREG(NREG), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (ctrl_bits)
    );

endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
    localparam int NREG = 11;
    localparam int DW   = 8;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic [1:0] sel = 2'b10;
    logic sda_oe;
    logic sda_line;
    logic [NREG*DW-1:0] ctrl;

    assign sda_line = sda_h & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regbank_slave dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .addr_sel  (sel),
        .sda_oe    (sda_oe),
        .ctrl_bits (ctrl)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int r12_viol = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return ctrl[i*8 +: 8];
    endfunction

    // Scoreboard monitor: compares observed read bytes against expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(o == e, t, "read byte", int'(o), int'(e));
            end
        end
    end

    // R12: target SDA drive must not change while SCL is high.
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl && scl_prev && (sda_oe !== oe_prev)) r12_viol++;
        scl_prev = scl;
        oe_prev  = sda_oe;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; qwait();
        scl = 1'b1;   qwait();
        sda_h = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qwait();
        scl = 1'b1;   qwait();
        sda_h = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1'b1; qwait();
        scl = 1'b1; qwait();
        b = sda_line; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        chk((!a) == exp_ack, req, "ack bit", int'(!a), int'(exp_ack));
    endtask

    task automatic read_byte(input bit give_ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        obs_q.push_back(v);
        send_bit(!give_ack);
    endtask

    task automatic expect_rd(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    localparam logic [7:0] WR = {5'b10110, 2'b10, 1'b0};
    localparam logic [7:0] RD = {5'b10110, 2'b10, 1'b1};

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [NREG*DW-1:0] snap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk(ctrl == '0, "R1", "ctrl after reset", int'(ctrl[31:0]), 0);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);

        // R2, R4: write three bytes from pointer 0x03
        bus_start();
        send_byte(WR, 1, "R2");
        send_byte(8'h03, 1, "R4");
        send_byte(8'hA1, 1, "R4");
        send_byte(8'hB2, 1, "R4");
        send_byte(8'hC3, 1, "R4");
        bus_stop();
        chk(reg_at(3) == 8'hA1, "R4", "reg3", int'(reg_at(3)), 'hA1);
        chk(reg_at(4) == 8'hB2, "R4", "reg4", int'(reg_at(4)), 'hB2);
        chk(reg_at(5) == 8'hC3, "R4", "reg5", int'(reg_at(5)), 'hC3);

        // R6, R9: pointer write, repeated start, sequential read ending in NACK
        bus_start();
        send_byte(WR, 1, "R6");
        send_byte(8'h03, 1, "R6");
        bus_start();
        send_byte(RD, 1, "R6");
        expect_rd(8'hA1, "R6"); read_byte(1);
        expect_rd(8'hB2, "R6"); read_byte(1);
        expect_rd(8'hC3, "R9"); read_byte(0);
        qwait();
        chk(sda_oe == 1'b0, "R9", "SDA released after NACK", int'(sda_oe), 0);
        scl = 1'b1; qwait();
        chk(sda_line == 1'b1, "R9", "line high after NACK", int'(sda_line), 1);
        scl = 1'b0; qwait();
        bus_stop();

        // R7: pointer survives a stop and a new start
        bus_start();
        send_byte(WR, 1, "R7");
        send_byte(8'h04, 1, "R7");
        bus_stop();
        bus_start();
        send_byte(RD, 1, "R7");
        expect_rd(8'hB2, "R7"); read_byte(1);
        expect_rd(8'hC3, "R7"); read_byte(0);
        bus_stop();

        // R5: writes past the last register pile up in register 0x0A
        bus_start();
        send_byte(WR, 1, "R5");
        send_byte(8'h09, 1, "R5");
        send_byte(8'h19, 1, "R5");
        send_byte(8'h2A, 1, "R5");
        send_byte(8'h3B, 1, "R5");
        send_byte(8'h4C, 1, "R5");
        bus_stop();
        chk(reg_at(9) == 8'h19, "R5", "reg9", int'(reg_at(9)), 'h19);
        chk(reg_at(10) == 8'h4C, "R5", "reg10 saturated", int'(reg_at(10)), 'h4C);
        chk(reg_at(0) == 8'h00, "R5", "reg0 not wrapped", int'(reg_at(0)), 0);

        // R8: reads saturate on register 0x0A
        bus_start();
        send_byte(WR, 1, "R8");
        send_byte(8'h09, 1, "R8");
        bus_start();
        send_byte(RD, 1, "R8");
        expect_rd(8'h19, "R8"); read_byte(1);
        expect_rd(8'h4C, "R8"); read_byte(1);
        expect_rd(8'h4C, "R8"); read_byte(1);
        expect_rd(8'h4C, "R8"); read_byte(0);
        bus_stop();

        // R10: pointer above the bank
        snap = ctrl;
        bus_start();
        send_byte(WR, 1, "R10");
        send_byte(8'h0C, 1, "R10");
        send_byte(8'h77, 1, "R10");
        bus_stop();
        chk(ctrl == snap, "R10", "bank unchanged by out-of-range write", 0, 0);
        bus_start();
        send_byte(WR, 1, "R10");
        send_byte(8'h0C, 1, "R10");
        bus_start();
        send_byte(RD, 1, "R10");
        expect_rd(8'h00, "R10"); read_byte(1);
        expect_rd(8'h00, "R10"); read_byte(0);
        bus_stop();

        // R3: foreign address
        snap = ctrl;
        bus_start();
        send_byte({5'b10110, 2'b01, 1'b0}, 0, "R3");
        send_byte(8'h00, 0, "R3");
        send_byte(8'h55, 0, "R3");
        bus_stop();
        chk(ctrl == snap, "R3", "bank unchanged after foreign address", 0, 0);

        // R11: stop in the middle of a data byte
        bus_start();
        send_byte(WR, 1, "R11");
        send_byte(8'h01, 1, "R11");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk(reg_at(1) == 8'h00, "R11", "reg1 after stop abort", int'(reg_at(1)), 0);

        // R11: repeated start in the middle of a data byte
        bus_start();
        send_byte(WR, 1, "R11");
        send_byte(8'h02, 1, "R11");
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte(WR, 1, "R11");
        send_byte(8'h07, 1, "R11");
        send_byte(8'h5E, 1, "R11");
        bus_stop();
        chk(reg_at(2) == 8'h00, "R11", "reg2 after start abort", int'(reg_at(2)), 0);
        chk(reg_at(7) == 8'h5E, "R11", "reg7 after restarted write", int'(reg_at(7)), 'h5E);

        // R2: other select-pin setting
        sel = 2'b01;
        qwait();
        bus_start();
        send_byte({5'b10110, 2'b01, 1'b0}, 1, "R2");
        send_byte(8'h00, 1, "R2");
        send_byte(8'h99, 1, "R2");
        bus_stop();
        chk(reg_at(0) == 8'h99, "R2", "reg0 via second address", int'(reg_at(0)), 'h99);

        // R12: continuous monitor result
        chk(r12_viol == 0, "R12", "SDA drive changes with SCL high", r12_viol, 0);

        // R1: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(ctrl == '0, "R1", "ctrl after second reset", int'(ctrl[31:0]), 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && obs_q.size() == 0, "R6", "scoreboard drained",
            obs_q.size(), exp_q.size());

        done = 1;
        finish_run();
    end

endmodule